// File: doc/BRIEF.md
# Cascadable Serial-In Latched Sink Driver

This block is a twelve-channel serial-to-parallel driver for sink-type loads. A host shifts a bit stream in on a shift clock pin. A separate latch clock pin then copies all twelve shift stages into a storage register in one step. Each channel's sink flag follows its storage bit while the active-low output gate is low, and every channel is forced off while the gate is high.

The last shift stage is brought out on a serial output, so several devices can share one bus in a chain. The serial output moves on the falling edge of the shift clock. A downstream device therefore samples a value that settled half a shift period before its own rising edge. An active-low clear empties the shift stages, the storage register and the serial output at once.

Both clock pins and the serial data pin are slow, asynchronous inputs. Each is brought into one fast system clock through a two-flop synchronizer. Pin edges are found by comparing successive synchronized samples, so all state is ordinary synchronous logic.

Top module: `latched_sink_driver`

## Requirements
- R1: A rising edge on `shiftClk` moves every shift stage k to stage k+1 for k = 0..10 and loads stage 0 with the level `serIn` had when the edge occurred. Without such an edge, the shift stages hold.
- R2: A rising edge on `latchClk` copies all twelve shift stages into the storage register in parallel. Without such an edge, the storage register holds. Storage bit i is shift stage i.
- R3: `sinkOn[i]` is 1 (channel conducting) exactly when `oeN` is 0 and storage bit i is 1. While `oeN` is 1, all `sinkOn` bits are 0, and the storage register keeps its content.
- R4: `serOut` carries shift stage 11. It changes only on a falling edge of `shiftClk`, where it takes the value stage 11 holds at that time.
- R5: While `clrN` is 0, the shift stages, storage register and `serOut` are zero. This takes effect without waiting for `clk` and overrides both pin clocks.
- R6: When rising edges of `shiftClk` and `latchClk` are seen in the same system cycle, the storage register receives the shift stages as they were before that shift.
- R7: A pin transition driven between system clock edges takes effect at the third rising edge of `clk` after it. Pin levels must be held for at least four `clk` cycles.
- R8: With two devices chained (`serOut` of the first into `serIn` of the second), shifting 24 bits in and latching leaves the first 12 bits shifted in the second device's storage, in shift order. The last 12 bits end up in the first device's storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all pins |
| rstN | input | 1 | Active-low asynchronous system reset |
| shiftClk | input | 1 | Shift clock pin (asynchronous) |
| latchClk | input | 1 | Latch clock pin (asynchronous) |
| serIn | input | 1 | Serial data pin |
| clrN | input | 1 | Active-low clear of shift stages, storage and serial output |
| oeN | input | 1 | Active-low output gate |
| serOut | output | 1 | Cascade output, last shift stage |
| sinkOn | output | NUM_CH | Per-channel sink-on flag |

## Verification
The assertions rely on a few things about the inputs. Each pin keeps its level for several system cycles. `serIn` is stable when `shiftClk` rises. `clrN` is never pulsed for less than a system cycle. The stimulus meets these by changing every input only on a falling `clk` edge and holding each pin-clock phase for four cycles. A reference model in the bench replays the pin history through its own three-sample window. The model is compared against both chained devices on every cycle, which also catches a serial output that moves on the wrong shift-clock edge.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  // Per-cycle strobes from the pin sampler to the datapath.
  typedef struct packed {
    logic shiftRise;  // rising edge seen on the shift clock pin
    logic shiftFall;  // falling edge seen on the shift clock pin
    logic latchRise;  // rising edge seen on the latch clock pin
    logic serBit;     // serial data, aligned with the shift clock samples
  } lsd_strobe_t;

endpackage

// File: rtl/lsd_sync.sv
module lsd_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[s] <= '0;
          else       chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/lsd_ctrl.sv
module lsd_ctrl
  import lsd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        shiftClk,
  input  logic        latchClk,
  input  logic        serIn,
  output lsd_strobe_t strobes
);

  localparam int NUM_PINS = 3;

  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_PINS-1:0] pinSync;
  logic                shiftPrev;
  logic                latchPrev;

  // Data travels through the same depth as the clocks, so it stays aligned.
  assign pinRaw = {serIn, latchClk, shiftClk};

  lsd_sync #(
    .WIDTH (NUM_PINS),
    .STAGES(SYNC_STAGES)
  ) pinSync_i (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(pinRaw),
    .syncOut(pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftPrev <= 1'b0;
      latchPrev <= 1'b0;
    end else begin
      shiftPrev <= pinSync[0];
      latchPrev <= pinSync[1];
    end
  end

  always_comb begin
    strobes.shiftRise = pinSync[0] & ~shiftPrev;
    strobes.shiftFall = ~pinSync[0] & shiftPrev;
    strobes.latchRise = pinSync[1] & ~latchPrev;
    strobes.serBit    = pinSync[2];
  end

endmodule

// File: rtl/lsd_datapath.sv
module lsd_datapath
  import lsd_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrN,
  input  logic              oeN,
  input  lsd_strobe_t       strobes,
  output logic              serOut,
  output logic [NUM_CH-1:0] sinkOn,
  output logic [NUM_CH-1:0] shiftStages,
  output logic [NUM_CH-1:0] storage
);

  localparam int LAST = NUM_CH - 1;

  logic anyClrN;
  assign anyClrN = rstN & clrN;

  // Shift stages: stage 0 takes new data, higher stages take the lower one.
  always_ff @(posedge clk or negedge anyClrN) begin
    if (!anyClrN)              shiftStages <= '0;
    else if (strobes.shiftRise) shiftStages <= {shiftStages[LAST-1:0], strobes.serBit};
  end

  // Storage copies the pre-shift stages, also when both edges coincide.
  always_ff @(posedge clk or negedge anyClrN) begin
    if (!anyClrN)              storage <= '0;
    else if (strobes.latchRise) storage <= shiftStages;
  end

  // Cascade output moves half a shift period after the shift itself.
  always_ff @(posedge clk or negedge anyClrN) begin
    if (!anyClrN)              serOut <= 1'b0;
    else if (strobes.shiftFall) serOut <= shiftStages[LAST];
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign sinkOn[i] = ~oeN & storage[i];
    end
  endgenerate

endmodule

// File: rtl/latched_sink_driver.sv
module latched_sink_driver
  import lsd_pkg::*;
#(
  parameter int NUM_CH      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftClk,
  input  logic              latchClk,
  input  logic              serIn,
  input  logic              clrN,
  input  logic              oeN,
  output logic              serOut,
  output logic [NUM_CH-1:0] sinkOn
);

  lsd_strobe_t       strobes;
  logic [NUM_CH-1:0] shiftStages;
  logic [NUM_CH-1:0] storage;

  lsd_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .shiftClk(shiftClk),
    .latchClk(latchClk),
    .serIn   (serIn),
    .strobes (strobes)
  );

  lsd_datapath #(
    .NUM_CH(NUM_CH)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .clrN       (clrN),
    .oeN        (oeN),
    .strobes    (strobes),
    .serOut     (serOut),
    .sinkOn     (sinkOn),
    .shiftStages(shiftStages),
    .storage    (storage)
  );

endmodule

// File: rtl/lsd_checker.sv
module lsd_checker
  import lsd_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              clrN,
  input logic              oeN,
  input logic              serOut,
  input logic [NUM_CH-1:0] sinkOn,
  input logic [NUM_CH-1:0] shiftStages,
  input logic [NUM_CH-1:0] storage,
  input lsd_strobe_t       strobes
);

  // R1
  shift_advance_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    strobes.shiftRise |=> shiftStages[NUM_CH-1:1] == $past(shiftStages[NUM_CH-2:0]));

  // R1
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !strobes.shiftRise |=> $stable(shiftStages));

  // R2 and R6: storage takes the stages as they were before any same-cycle shift
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    strobes.latchRise |=> storage == $past(shiftStages));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !strobes.latchRise |=> $stable(storage));

  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> sinkOn == '0);

  // R3
  gate_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    !oeN |-> sinkOn == storage);

  // R4
  ser_out_stable_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !strobes.shiftFall |=> $stable(serOut));

  // R4
  ser_out_value_chk: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    strobes.shiftFall |=> serOut == $past(shiftStages[NUM_CH-1]));

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> (shiftStages == '0) && (storage == '0) && !serOut);

  // R7: a pin level is seen as either rising or falling, never both
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.shiftRise && strobes.shiftFall));

endmodule

bind latched_sink_driver lsd_checker #(.NUM_CH(NUM_CH)) chk_i (.*);

// File: tb/latched_sink_driver_tb.sv
module latched_sink_driver_tb_top;

  localparam int N = 12;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftClk = 1'b0;
  logic latchClk = 1'b0;
  logic serIn = 1'b0;
  logic clrN = 1'b1;
  logic oeN = 1'b1;
  logic serOutA, serOutB;
  logic [N-1:0] sinkA, sinkB;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  latched_sink_driver dut_i (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .latchClk(latchClk),
    .serIn(serIn), .clrN(clrN), .oeN(oeN), .serOut(serOutA), .sinkOn(sinkA));

  latched_sink_driver dut2_i (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .latchClk(latchClk),
    .serIn(serOutA), .clrN(clrN), .oeN(oeN), .serOut(serOutB), .sinkOn(sinkB));

  // Behavioural reference: pin samples kept newest first, two devices in a chain.
  logic [N-1:0] mSh [2];
  logic [N-1:0] mSt [2];
  logic         mSo [2];
  logic [2:0]   hSc, hLc, hSiA, hSiB;

  task automatic modelClear();
    for (int d = 0; d < 2; d++) begin
      mSh[d] = '0; mSt[d] = '0; mSo[d] = 1'b0;
    end
  endtask

  always @(negedge clrN) modelClear();

  always @(posedge clk) begin
    if (!rstN) begin
      modelClear();
      hSc = '0; hLc = '0; hSiA = '0; hSiB = '0;
    end else begin
      logic sR, sF, lR, pinSo;
      logic [1:0] ser;
      sR = hSc[1] && !hSc[2];
      sF = !hSc[1] && hSc[2];
      lR = hLc[1] && !hLc[2];
      ser[0] = hSiA[1];
      ser[1] = hSiB[1];
      pinSo = mSo[0];
      if (!clrN) modelClear();
      else begin
        for (int d = 0; d < 2; d++) begin
          logic [N-1:0] old;
          old = mSh[d];
          if (lR) mSt[d] = old;
          if (sR) mSh[d] = {old[N-2:0], ser[d]};
          if (sF) mSo[d] = old[N-1];
        end
      end
      hSc  = {hSc[1:0], shiftClk};
      hLc  = {hLc[1:0], latchClk};
      hSiA = {hSiA[1:0], serIn};
      hSiB = {hSiB[1:0], pinSo};
    end
  end

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      chk("R3 dev0 sinkOn", sinkA, oeN ? '0 : mSt[0]);
      chk("R8 dev1 sinkOn", sinkB, oeN ? '0 : mSt[1]);
      chk("R4 dev0 serOut", {{(N-1){1'b0}}, serOutA}, {{(N-1){1'b0}}, mSo[0]});
      chk("R4 dev1 serOut", {{(N-1){1'b0}}, serOutB}, {{(N-1){1'b0}}, mSo[1]});
    end
  end

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 200000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBit(logic b);
    serIn = b; shiftClk = 1'b1; cyc(HOLD);
    shiftClk = 1'b0; cyc(HOLD);
  endtask

  task automatic latchPulse();
    latchClk = 1'b1; cyc(HOLD);
    latchClk = 1'b0; cyc(HOLD);
  endtask

  task automatic clearPulse();
    clrN = 1'b0; cyc(2); clrN = 1'b1; cyc(2);
  endtask

  initial begin
    logic [23:0] pat;
    pat = 24'h5A3_9E5;
    cyc(4);
    rstN = 1'b1;
    cyc(2);
    oeN = 1'b0;
    cyc(1);
    chk("R3 reset sinks dev0", sinkA, '0);
    chk("R4 reset serOut dev0", {{(N-1){1'b0}}, serOutA}, '0);

    // R1: four bits, the first one shifted sits deepest
    shiftBit(1); shiftBit(0); shiftBit(1); shiftBit(1);
    chk("R2 no latch yet", sinkA, '0);
    latchPulse();
    chk("R1 shifted pattern", sinkA, 12'h00B);

    // R5: clear is immediate and overrides the pin clocks
    clrN = 1'b0;
    #1;
    chk("R5 async clear sinks", sinkA, '0);
    chk("R5 async clear serOut", {{(N-1){1'b0}}, serOutA}, '0);
    shiftBit(1);
    latchPulse();
    chk("R5 clocks ignored in clear", sinkA, '0);
    clrN = 1'b1;
    cyc(2);

    // R8: 24 bits through the chain, first bit first
    for (int i = 23; i >= 0; i--) shiftBit(pat[i]);
    latchPulse();
    chk("R8 downstream storage", sinkB, pat[23:12]);
    chk("R8 upstream storage", sinkA, pat[11:0]);

    // R4: output holds through the rising phase, moves on the falling one
    serIn = 1'b0; shiftClk = 1'b1; cyc(HOLD);
    chk("R4 held after rise", {{(N-1){1'b0}}, serOutA}, {{(N-1){1'b0}}, pat[11]});
    shiftClk = 1'b0; cyc(HOLD);
    chk("R4 moved after fall", {{(N-1){1'b0}}, serOutA}, {{(N-1){1'b0}}, pat[10]});

    // R3: gate forces all off, storage intact afterwards
    oeN = 1'b1; cyc(1);
    chk("R3 gated dev0", sinkA, '0);
    chk("R3 gated dev1", sinkB, '0);
    oeN = 1'b0; cyc(1);
    chk("R3 ungated dev1", sinkB, pat[23:12]);

    // R6: coincident edges latch the pre-shift stages
    clearPulse();
    shiftBit(1);
    latchPulse();
    chk("R6 setup", sinkA, 12'h001);
    serIn = 1'b1; shiftClk = 1'b1; latchClk = 1'b1; cyc(HOLD);
    shiftClk = 1'b0; latchClk = 1'b0; cyc(HOLD);
    chk("R6 pre-shift captured", sinkA, 12'h001);
    latchPulse();
    chk("R2 later latch", sinkA, 12'h003);

    // R7: pin change acts at the third rising clk edge
    shiftBit(1);
    latchClk = 1'b1;
    cyc(2);
    chk("R7 not yet after two edges", sinkA, 12'h003);
    cyc(1);
    chk("R7 updated at third edge", sinkA, 12'h007);
    latchClk = 1'b0;
    cyc(HOLD);

    finishRun();
  end

endmodule